// File: doc/BRIEF.md
# APB Down-Counter Timer

This block is a decrementing counter with a single interrupt line, controlled over a zero-wait-state APB slave port. Software writes a start value, selects free-running or periodic operation, and enables the timer. The counter then drops by one on each enabled clock.

When the counter is found at zero on an enabled clock, a sticky raw interrupt flag is set. At the same time the counter either reloads from the stored reload value (periodic) or wraps to all ones (free-running). The reload value has two write paths. One also restarts the count at once. The other only changes what the next periodic reload will use, so a running period can be retuned without a glitch. The interrupt flag stays set until software writes any value to a dedicated clear location. The interrupt output is the flag gated by an enable bit.

Top module: `dntimer_apb`

## Requirements
- R1: After reset the count reads 0xFFFFFFFF, the reload value reads 0, the control word reads 0x20 (interrupt enable set, timer stopped, free-running), the raw flag is 0 and `irq` is low.
- R2: Every transfer completes in its access phase, with `pready` high and `pslverr` low. A write takes effect when `psel`, `penable` and `pwrite` are all high. Offsets are decoded from `paddr[7:0]`: 0x20 reload/restart (RW), 0x24 current count (RO), 0x28 control (RW), 0x2C clear (WO, reads 0), 0x30 raw status, 0x34 masked status, 0x38 background reload (RW). Any other offset reads 0.
- R3: In the control word, bit 7 is the enable, bit 6 selects periodic mode and bit 5 is the interrupt enable. These bits read back as written, and all other bits read 0. While enabled, the count falls by one per clock. While disabled, it holds.
- R4: A write to 0x20 loads the data into the reload value, and into the count at the same clock edge. This load takes priority over decrementing.
- R5: A write to 0x38 changes only the reload value, and the count keeps decrementing. Reads of 0x20 and 0x38 both return the reload value.
- R6: On an enabled clock with the count at zero, the raw flag is set. In periodic mode the count takes the reload value, so a reload value L gives an event every L+1 enabled clocks.
- R7: In free-running mode, the enabled clock at zero sets the raw flag and makes the count 0xFFFFFFFF.
- R8: A write of any data to 0x2C clears the raw flag. If a zero event occurs on the same clock, the flag stays set.
- R9: Bit 0 of 0x30 is the raw flag. Bit 0 of 0x34 and the `irq` output both equal the raw flag ANDed with the interrupt enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | Clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write (1) or read (0) |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | DATA_W | APB write data |
| prdata | output | DATA_W | APB read data |
| pready | output | 1 | Always high |
| pslverr | output | 1 | Always low |
| irq | output | 1 | Masked timer interrupt |

## Verification
The hardest case to reach from the ports is the exact clock on which the counter passes zero. This depends on counting every APB phase between the enabling write and the event. The stimulus therefore stops the timer, clears the flag and preloads a small value, then enables it with a single write. After that it polls `irq` on each falling edge and expects the first event exactly L+1 clocks after the enabling edge. This is swept over reload values 0 to 7 in both modes. The counter value after the event is then read back and compared with a small arithmetic model of reload versus wrap. A background reload on a running counter is checked by reading the count a known number of clocks later.

// File: rtl/dntimer_pkg.sv
package dntimer_pkg;
   localparam int OFS_W = 8;

   localparam logic [OFS_W-1:0] OFS_RELOAD = 8'h20;
   localparam logic [OFS_W-1:0] OFS_COUNT  = 8'h24;
   localparam logic [OFS_W-1:0] OFS_CTRL   = 8'h28;
   localparam logic [OFS_W-1:0] OFS_CLEAR  = 8'h2C;
   localparam logic [OFS_W-1:0] OFS_RAW    = 8'h30;
   localparam logic [OFS_W-1:0] OFS_MASKED = 8'h34;
   localparam logic [OFS_W-1:0] OFS_BGLD   = 8'h38;

   localparam int CTL_RUN = 7;
   localparam int CTL_PER = 6;
   localparam int CTL_IE  = 5;

   typedef struct packed {
      logic run;
      logic per;
      logic ie;
   } ctl_t;

   typedef struct packed {
      logic reload;
      logic bgld;
      logic ctrl;
      logic clear;
   } wstb_t;
endpackage

// File: rtl/dntimer_regif.sv
module dntimer_regif
   import dntimer_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 8
) (
   input  logic              psel,
   input  logic              penable,
   input  logic              pwrite,
   input  logic [ADDR_W-1:0] paddr,
   input  logic [DATA_W-1:0] cnt,
   input  logic [DATA_W-1:0] rl,
   input  ctl_t              ctl,
   input  logic              raw,
   output wstb_t             wstb,
   output logic [DATA_W-1:0] prdata
);
   logic [OFS_W-1:0] ofs;
   logic             wr_en;

   assign ofs   = paddr[OFS_W-1:0];
   assign wr_en = psel & penable & pwrite;

   always_comb begin
      wstb.reload = wr_en && (ofs == OFS_RELOAD);
      wstb.bgld   = wr_en && (ofs == OFS_BGLD);
      wstb.ctrl   = wr_en && (ofs == OFS_CTRL);
      wstb.clear  = wr_en && (ofs == OFS_CLEAR);
   end

   always_comb begin
      prdata = '0;
      case (ofs)
         OFS_RELOAD, OFS_BGLD: prdata = rl;
         OFS_COUNT:            prdata = cnt;
         OFS_CTRL: begin
            prdata[CTL_RUN] = ctl.run;
            prdata[CTL_PER] = ctl.per;
            prdata[CTL_IE]  = ctl.ie;
         end
         OFS_RAW:              prdata[0] = raw;
         OFS_MASKED:           prdata[0] = raw & ctl.ie;
         default:              prdata = '0;
      endcase
   end
endmodule

// File: rtl/dntimer_core.sv
module dntimer_core
   import dntimer_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter bit RST_IE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  wstb_t             wstb,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] cnt,
   output logic [DATA_W-1:0] rl,
   output ctl_t              ctl,
   output logic              raw
);
   localparam logic [DATA_W-1:0] ALL_ONES = '1;

   logic at_zero;
   logic zero_evt;
   logic [DATA_W-1:0] cnt_nxt;

   assign at_zero  = (cnt == '0);
   assign zero_evt = ctl.run & ~wstb.reload & at_zero;

   always_comb begin
      if (wstb.reload)
         cnt_nxt = wdata;
      else if (!ctl.run)
         cnt_nxt = cnt;
      else if (at_zero)
         cnt_nxt = ctl.per ? rl : ALL_ONES;
      else
         cnt_nxt = cnt - 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= ALL_ONES;
         rl      <= '0;
         ctl.run <= 1'b0;
         ctl.per <= 1'b0;
         ctl.ie  <= RST_IE;
         raw     <= 1'b0;
      end else begin
         cnt <= cnt_nxt;
         if (wstb.reload || wstb.bgld)
            rl <= wdata;
         if (wstb.ctrl) begin
            ctl.run <= wdata[CTL_RUN];
            ctl.per <= wdata[CTL_PER];
            ctl.ie  <= wdata[CTL_IE];
         end
         if (zero_evt)
            raw <= 1'b1;
         else if (wstb.clear)
            raw <= 1'b0;
      end
   end
endmodule

// File: rtl/dntimer_apb.sv
module dntimer_apb
   import dntimer_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 8,
   parameter bit RST_IE = 1'b1
) (
   input  logic              pclk,
   input  logic              presetn,
   input  logic              psel,
   input  logic              penable,
   input  logic              pwrite,
   input  logic [ADDR_W-1:0] paddr,
   input  logic [DATA_W-1:0] pwdata,
   output logic [DATA_W-1:0] prdata,
   output logic              pready,
   output logic              pslverr,
   output logic              irq
);
   generate
      if (DATA_W < CTL_RUN + 1) begin : g_bad_data_w
         $error("DATA_W too narrow for control bits");
      end
      if (ADDR_W < OFS_W) begin : g_bad_addr_w
         $error("ADDR_W must cover the register offsets");
      end
   endgenerate

   wstb_t             wstb;
   logic [DATA_W-1:0] cnt_q;
   logic [DATA_W-1:0] rl_q;
   ctl_t              ctl_q;
   logic              raw_q;

   dntimer_regif #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regif (
      .psel    (psel),
      .penable (penable),
      .pwrite  (pwrite),
      .paddr   (paddr),
      .cnt     (cnt_q),
      .rl      (rl_q),
      .ctl     (ctl_q),
      .raw     (raw_q),
      .wstb    (wstb),
      .prdata  (prdata)
   );

   dntimer_core #(.DATA_W(DATA_W), .RST_IE(RST_IE)) u_core (
      .clk   (pclk),
      .rst_n (presetn),
      .wstb  (wstb),
      .wdata (pwdata),
      .cnt   (cnt_q),
      .rl    (rl_q),
      .ctl   (ctl_q),
      .raw   (raw_q)
   );

   assign pready  = 1'b1;
   assign pslverr = 1'b0;
   assign irq     = raw_q & ctl_q.ie;
endmodule

// File: rtl/dntimer_apb_chk.sv
module dntimer_apb_chk #(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic [DATA_W-1:0] pwdata,
   input logic              pready,
   input logic              pslverr,
   input logic              irq,
   input logic [DATA_W-1:0] cnt,
   input logic              raw,
   input logic              run,
   input logic              per,
   input logic              ie,
   input logic              wr_reload,
   input logic              wr_bgld,
   input logic              wr_clear
);
   logic zero_evt;
   assign zero_evt = run && !wr_reload && (cnt == '0);

   always @(negedge clk) begin
      if (rst_n) begin
         assert_apb_nowait_R2: assert (pready && !pslverr);
      end
   end

   assert_hold_when_stopped_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !wr_reload) |=> (cnt == $past(cnt)));

   assert_decrement_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !wr_reload && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

   assert_reload_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_reload |=> (cnt == $past(pwdata)));

   assert_bg_no_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_bgld && run && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

   assert_zero_sets_raw_R6: assert property (@(posedge clk) disable iff (!rst_n)
      zero_evt |=> raw);

   assert_free_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (zero_evt && !per) |=> (&cnt));

   assert_clear_raw_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_clear && !zero_evt) |=> !raw);

   assert_irq_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
      irq == (raw && ie));
endmodule

bind dntimer_apb dntimer_apb_chk #(.DATA_W(DATA_W)) u_chk (
   .clk       (pclk),
   .rst_n     (presetn),
   .pwdata    (pwdata),
   .pready    (pready),
   .pslverr   (pslverr),
   .irq       (irq),
   .cnt       (cnt_q),
   .raw       (raw_q),
   .run       (ctl_q.run),
   .per       (ctl_q.per),
   .ie        (ctl_q.ie),
   .wr_reload (wstb.reload),
   .wr_bgld   (wstb.bgld),
   .wr_clear  (wstb.clear)
);

// File: tb/dntimer_apb_tb.sv
module dntimer_apb_tb;
   localparam int CLK_P = 10;
   localparam int WD_CYC = 100000;

   localparam logic [7:0] A_RL = 8'h20, A_CNT = 8'h24, A_CTL = 8'h28, A_CLR = 8'h2C;
   localparam logic [7:0] A_RAW = 8'h30, A_MSK = 8'h34, A_BG = 8'h38;

   logic        clk = 1'b0;
   logic        presetn = 1'b0;
   logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
   logic [7:0]  paddr = '0;
   logic [31:0] pwdata = '0;
   logic [31:0] prdata;
   logic        pready, pslverr, irq;

   int n_cmp = 0;
   int n_bad = 0;

   always #(CLK_P/2) clk = ~clk;

   dntimer_apb u_dut (
      .pclk(clk), .presetn(presetn), .psel(psel), .penable(penable),
      .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
      .pready(pready), .pslverr(pslverr), .irq(irq)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
      end
   endtask

   task automatic apb_wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk); psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
      @(negedge clk); penable = 1;
      @(negedge clk); psel = 0; penable = 0; pwrite = 0;
   endtask

   task automatic apb_rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk); psel = 1; pwrite = 0; paddr = a; penable = 0;
      @(negedge clk); penable = 1; d = prdata;
      chk("R2 pready/pslverr", {30'd0, pready, pslverr}, 32'd2);
      @(negedge clk); psel = 0; penable = 0;
   endtask

   function automatic logic [31:0] nxt(input logic [31:0] c, input bit per, input logic [31:0] l);
      return (c == 0) ? (per ? l : 32'hFFFF_FFFF) : c - 1;
   endfunction

   initial begin
      repeat (WD_CYC) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      logic [31:0] d, e, v0;
      repeat (3) @(negedge clk);
      presetn = 1;

      // R1 reset state
      chk("R1 irq", {31'd0, irq}, 0);
      apb_rd(A_CNT, d); chk("R1 count", d, 32'hFFFF_FFFF);
      apb_rd(A_CTL, d); chk("R1 control", d, 32'h20);
      apb_rd(A_RL, d);  chk("R1 reload", d, 0);
      apb_rd(A_RAW, d); chk("R1 raw", d, 0);

      // R3 hold when stopped, decrement when running
      apb_wr(A_RL, 1000);
      apb_rd(A_CNT, d); chk("R3 held", d, 1000);
      apb_rd(A_CNT, d); chk("R3 held again", d, 1000);
      apb_wr(A_CTL, 32'hA0);
      apb_rd(A_CNT, d); chk("R3 decrement", d, 998);
      apb_rd(A_CNT, d); chk("R3 decrement span", d, 995);
      apb_rd(A_CTL, d); chk("R3 control readback", d, 32'hA0);

      // R4 restart on reload write while running
      apb_wr(A_RL, 500);
      apb_rd(A_CNT, v0); chk("R4 restart", v0, 498);
      apb_rd(A_RL, d);   chk("R4 reload value", d, 500);

      // R5 background reload does not restart
      apb_wr(A_BG, 77);
      apb_rd(A_CNT, d); chk("R5 no restart", d, v0 - 9);
      apb_rd(A_BG, d);  chk("R5 bg readback", d, 77);
      apb_rd(A_RL, d);  chk("R5 shared reload", d, 77);

      // R6 / R7 sweep: first event at L+1 clocks, then reload or wrap
      for (int m = 0; m < 2; m++) begin
         for (int l = 0; l < 8; l++) begin
            apb_wr(A_CTL, 0);
            apb_wr(A_CLR, 32'hDEAD_BEEF);
            apb_wr(A_RL, l);
            apb_wr(A_CTL, 32'hA0 | (m << 6));
            for (int j = 1; j <= l + 1; j++) begin
               @(negedge clk);
               if (j == l && m == 1) chk("R6 no early event", {31'd0, irq}, 0);
               if (j == l && m == 0) chk("R7 no early event", {31'd0, irq}, 0);
               if (j == l + 1 && m == 1) chk("R6 event time", {31'd0, irq}, 1);
               if (j == l + 1 && m == 0) chk("R7 event time", {31'd0, irq}, 1);
            end
            e = (m == 1) ? l : 32'hFFFF_FFFF;
            e = nxt(nxt(e, m == 1, l), m == 1, l);
            apb_rd(A_CNT, d);
            if (m == 1) chk("R6 reload count", d, e);
            else        chk("R7 wrap count", d, e);
         end
      end

      // R9 masking, R8 clear, R2 unmapped reads
      apb_wr(A_CTL, 0);
      apb_wr(A_CLR, 0);
      apb_wr(A_RL, 0);
      apb_wr(A_CTL, 32'h80);
      apb_wr(A_CTL, 0);
      apb_rd(A_RAW, d); chk("R9 raw set while masked", d, 1);
      apb_rd(A_MSK, d); chk("R9 masked status off", d, 0);
      chk("R9 irq masked", {31'd0, irq}, 0);
      apb_wr(A_CTL, 32'h20);
      apb_rd(A_MSK, d); chk("R9 masked status on", d, 1);
      chk("R9 irq on", {31'd0, irq}, 1);
      apb_wr(A_CLR, 32'h1234_5678);
      apb_rd(A_RAW, d); chk("R8 raw cleared", d, 0);
      chk("R8 irq cleared", {31'd0, irq}, 0);
      apb_rd(A_CLR, d); chk("R2 clear reads zero", d, 0);
      apb_rd(8'h3C, d); chk("R2 unmapped 0x3C", d, 0);
      apb_rd(8'h10, d); chk("R2 unmapped 0x10", d, 0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule